// File: doc/BRIEF.md
# Single-Ported Tag Access Arbiter

This block decides, once per clock, which of three requesters may use a cache tag array that accepts only one access per cycle. The requesters are snoop lookups from other bus masters, processor loads and stores, and tag writes issued by line fills and coherency state changes. Exactly one requester, or none, is granted in each cycle.

Snoops normally come first. A snoop that meets a tag write in the same cycle gets a one-cycle retry and must ask again. A load or store that loses is stalled for one cycle. It is then granted in the very next cycle, whatever else arrives in that cycle. Requests are sampled on the rising edge. Grant, stall and retry are registered and appear in the cycle that follows the sampling edge. A load/store requester that is stalled keeps its request raised until it is granted.

Top module: `tag_port_arbiter`

## Requirements
- R1: A synchronous active-low reset drives every output low and clears any pending deferral, so the first cycle after reset grants no load/store unless one is requested.
- R2: At most one of the three grant outputs is high in any cycle.
- R3: A snoop request presented alone is granted in the following cycle.
- R4: When a snoop and a load/store are presented together and no deferral is pending, the snoop is granted and the load/store stall is high in the following cycle.
- R5: A load/store that was stalled is granted in the cycle right after the stall cycle, and the stall output is then low.
- R6: When a snoop and a tag write are presented together and no deferral is pending, the tag write is granted and the snoop retry is high in the following cycle.
- R7: A snoop that arrives while a deferred load/store is being served is retried, not granted.
- R8: When a tag write and a load/store are presented together, the tag write is granted and the load/store is stalled for exactly one cycle.
- R9: A tag write presented while a deferred load/store is being served is neither granted nor retried in that cycle.
- R10: A load/store presented alone is granted in the following cycle, with no stall.
- R11: With no request presented, every output is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| snp_req | input | 1 | Snoop lookup request |
| ls_req | input | 1 | Processor load/store request, held while stalled |
| tw_req | input | 1 | Tag write request from fill or state update |
| snp_gnt | output | 1 | Snoop granted the tag port |
| ls_gnt | output | 1 | Load/store granted the tag port |
| tw_gnt | output | 1 | Tag write granted the tag port |
| snp_retry | output | 1 | Snoop refused this cycle; it must arbitrate again |
| ls_stall | output | 1 | Load/store deferred; it is served next cycle |

## Verification
The only internal state is the pending-deferral flag. If it is wrong, the fault shows at the ports one cycle after the stall. A flag that was lost shows up as a missing load/store grant, or as a snoop granted where it should have been retried. A flag that is stuck or stale shows up as a load/store grant with no request, or as a grant right after reset. The grant, stall and retry outputs are registered, so every wrong decision appears exactly one cycle after the requests that caused it.

// File: rtl/tag_arb_pkg.sv
package tag_arb_pkg;

    // Registered decision of the arbiter for one cycle
    typedef struct packed {
        logic snp_gnt;
        logic ls_gnt;
        logic tw_gnt;
        logic snp_retry;
        logic ls_stall;
        logic defer;      // a load/store owns the next cycle
    } arb_state_t;

    localparam arb_state_t ARB_IDLE = '0;

endpackage

// File: rtl/tag_arb_pick.sv
module tag_arb_pick
    import tag_arb_pkg::*;
(
    input  logic       snp_req,
    input  logic       ls_req,
    input  logic       tw_req,
    input  logic       defer_q,
    output arb_state_t pick_d
);

    always_comb begin
        pick_d = ARB_IDLE;
        if (defer_q) begin
            // deferred load/store owns this cycle unconditionally
            pick_d.ls_gnt    = 1'b1;
            pick_d.snp_retry = snp_req;
        end else if (tw_req) begin
            pick_d.tw_gnt    = 1'b1;
            pick_d.snp_retry = snp_req;
            pick_d.ls_stall  = ls_req;
            pick_d.defer     = ls_req;
        end else if (snp_req) begin
            pick_d.snp_gnt   = 1'b1;
            pick_d.ls_stall  = ls_req;
            pick_d.defer     = ls_req;
        end else if (ls_req) begin
            pick_d.ls_gnt    = 1'b1;
        end
    end

endmodule

// File: rtl/tag_arb_regs.sv
module tag_arb_regs
    import tag_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  arb_state_t state_d,
    output arb_state_t state_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({state_q.snp_gnt, state_q.ls_gnt, state_q.tw_gnt}));

    // R5
    stall_then_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ls_stall |=> (state_q.ls_gnt && !state_q.ls_stall));

    // R4
    stall_has_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ls_stall |-> (state_q.snp_gnt || state_q.tw_gnt));

    // R6
    retry_has_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.snp_retry |-> ((state_q.tw_gnt || state_q.ls_gnt) && !state_q.snp_gnt));

endmodule

// File: rtl/tag_port_arbiter.sv
module tag_port_arbiter
    import tag_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic snp_req,
    input  logic ls_req,
    input  logic tw_req,
    output logic snp_gnt,
    output logic ls_gnt,
    output logic tw_gnt,
    output logic snp_retry,
    output logic ls_stall
);

    arb_state_t arb_d;
    arb_state_t arb_q;

    tag_arb_pick pick_i (
        .snp_req (snp_req),
        .ls_req  (ls_req),
        .tw_req  (tw_req),
        .defer_q (arb_q.defer),
        .pick_d  (arb_d)
    );

    tag_arb_regs regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (arb_d),
        .state_q (arb_q)
    );

    assign snp_gnt   = arb_q.snp_gnt;
    assign ls_gnt    = arb_q.ls_gnt;
    assign tw_gnt    = arb_q.tw_gnt;
    assign snp_retry = arb_q.snp_retry;
    assign ls_stall  = arb_q.ls_stall;

    // R7
    deferred_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(arb_q.defer) && $past(snp_req)) |-> (snp_retry && !snp_gnt));

endmodule

// File: tb/tag_port_arbiter_tb_top.sv
module tag_port_arbiter_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snp_req = 1'b0, ls_req = 1'b0, tw_req = 1'b0;
    logic snp_gnt, ls_gnt, tw_gnt, snp_retry, ls_stall;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    tag_port_arbiter dut_i (
        .clk(clk), .rst_n(rst_n),
        .snp_req(snp_req), .ls_req(ls_req), .tw_req(tw_req),
        .snp_gnt(snp_gnt), .ls_gnt(ls_gnt), .tw_gnt(tw_gnt),
        .snp_retry(snp_retry), .ls_stall(ls_stall)
    );

    // {snp,ls,tw inputs, snp_gnt,ls_gnt,tw_gnt,retry,stall expected}, req number
    localparam int NV = 13;
    localparam logic [7:0] VEC [NV] = '{
        8'b000_00000,  // R11 idle
        8'b100_10000,  // R3 snoop alone
        8'b010_01000,  // R10 load/store alone
        8'b001_00100,  // tag write alone
        8'b110_10001,  // R4 snoop beats load/store
        8'b110_01010,  // R5 R7 deferred served, new snoop retried
        8'b101_00110,  // R6 snoop vs tag write
        8'b011_00101,  // R8 tag write beats load/store
        8'b011_01000,  // R9 tag write waits during deferral
        8'b001_00100,  // tag write gets through afterwards
        8'b111_00111,  // R6 R8 all three
        8'b010_01000,  // R5 deferred served
        8'b000_00000   // R11 idle
    };
    localparam int REQ [NV] = '{11, 3, 10, 2, 4, 5, 6, 8, 9, 2, 6, 5, 11};

    task automatic check(input int req, input logic [4:0] exp);
        logic [4:0] act;
        act = {snp_gnt, ls_gnt, tw_gnt, snp_retry, ls_stall};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d: outputs {sg,lg,tg,retry,stall} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] in);
        @(negedge clk);
        {snp_req, ls_req, tw_req} = in;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check(1, 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][7:5]);
            check(REQ[i], VEC[i][4:0]);
        end

        // R1 reset clears a pending deferral
        step(3'b110);
        check(4, 5'b10001);
        @(negedge clk);
        rst_n = 1'b0;
        ls_req = 1'b0; snp_req = 1'b0;
        @(posedge clk);
        #1;
        check(1, 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;
        step(3'b000);
        check(1, 5'b00000);

        // R7 back-to-back snoop pressure keeps deferral guarantee
        step(3'b110);
        check(4, 5'b10001);
        step(3'b110);
        check(7, 5'b01010);
        step(3'b100);
        check(3, 5'b10000);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule